// File: doc/BRIEF.md
# Inbound Interrupt Message Write Router

This block takes inbound memory writes from two downstream requesters, a hub link port and a PCI-style port, and holds them in a small posted-write queue. A write is either taken into the queue in the cycle it is presented, or the requester is told in that same cycle to retry, and nothing is stored. The hub link has fixed priority over the PCI-style port.

Sorting happens only once a write has been posted. At the head of the queue an entry is decoded by address: if its top twelve address bits equal 0xFEE and its source may carry interrupt messages, it leaves on the interrupt transaction output. Any other entry leaves on the ordinary memory write output. Both outputs share one queue, so writes leave in the order they were accepted, whichever output they take. Each output has a valid/ready handshake.

Top module: `intr_write_router`

## Requirements
- R1: A posted write from the hub link port whose address bits [31:20] equal 0xFEE leaves on the interrupt output (`irq_out_*`). Every other hub link write leaves on the memory output (`mem_out_*`). The address and data leave unchanged.
- R2: A write from the PCI-style port with `pci_pcisem`=1 is classified exactly as a hub link write. With `pci_pcisem`=0 the write is still accepted, but it always leaves on the memory output, whatever its address.
- R3: When only one port requests, the write is accepted (retry low) if fewer than 4 entries are queued. With 4 queued, the port's retry output goes high in the same cycle and the write is not stored.
- R4: When both ports request in the same cycle, the hub link write is handled as in R3. The PCI-style write is accepted only if at least 2 slots are free, and is otherwise retried. When both are accepted, the hub link entry is ordered ahead of the PCI-style entry.
- R5: Entries leave in acceptance order across both outputs. At most one output is valid in any cycle, and it presents the oldest queued entry.
- R6: While an output is valid and its ready is low, that output stays valid and its address and data hold steady.
- R7: Free space is judged on the occupancy at the start of the cycle. An entry leaving in the same cycle does not make room for a new write in that cycle.
- R8: During and right after reset the queue is empty, both output valids are low, and the retry outputs are low.
- R9: A retry output is high only while its own port's valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| hub_valid | input | 1 | Hub link write request |
| hub_addr | input | 32 | Hub link write address |
| hub_data | input | 32 | Hub link write data |
| hub_retry | output | 1 | Hub link write rejected this cycle |
| pci_valid | input | 1 | PCI-style port write request |
| pci_pcisem | input | 1 | Write carries PCI semantics (may be an interrupt message) |
| pci_addr | input | 32 | PCI-style write address |
| pci_data | input | 32 | PCI-style write data |
| pci_retry | output | 1 | PCI-style write rejected this cycle |
| mem_out_valid | output | 1 | Ordinary memory write available |
| mem_out_ready | input | 1 | Consumer takes the ordinary write |
| mem_out_addr | output | 32 | Ordinary write address |
| mem_out_data | output | 32 | Ordinary write data |
| irq_out_valid | output | 1 | Interrupt message transaction available |
| irq_out_ready | input | 1 | Consumer takes the interrupt transaction |
| irq_out_addr | output | 32 | Interrupt message address |
| irq_out_data | output | 32 | Interrupt message data |

## Verification
Several rules are checked on every cycle by assertions. The queue never takes a write while full. A retry never appears without a request. The PCI-style write is never accepted while a competing hub link write is turned away. Only one output is valid at a time, the interrupt output only ever carries window addresses from eligible sources, and a stalled output holds its contents. The bench scenarios are needed for the rest. They compare outputs against a reference queue and so show the global ordering across both outputs, the exact two-slot threshold when both ports collide, the rule that a same-cycle departure frees no slot, and the treatment of PCI-style writes without PCI semantics.

// File: rtl/iwr_pkg.sv
package iwr_pkg;
   localparam int unsigned IWR_ADDR_W   = 32;
   localparam int unsigned IWR_DATA_W   = 32;
   localparam int unsigned IWR_DEPTH    = 4;
   localparam int unsigned IWR_WIN_BITS = 12;
   localparam logic [IWR_WIN_BITS-1:0] IWR_WIN_TAG = 12'hFEE;

   typedef enum logic [0:0] {
      SRC_HUB = 1'b0,
      SRC_PCI = 1'b1
   } iwr_src_e;

   // A source may produce interrupt messages unless it is the PCI-style
   // port without PCI semantics.
   function automatic logic iwr_irq_eligible(iwr_src_e src, logic pcisem);
      return (src == SRC_HUB) || pcisem;
   endfunction
endpackage

// File: rtl/iwr_ingress_arb.sv
module iwr_ingress_arb #(
   parameter int unsigned DEPTH = iwr_pkg::IWR_DEPTH,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hub_vld,
   input  logic          pci_vld,
   input  logic [CW-1:0] occupancy,
   output logic          hub_push,
   output logic          pci_push,
   output logic          hub_rty,
   output logic          pci_rty
);
   logic [CW-1:0] free_slots;
   logic          hub_fits;
   logic          pci_fits;

   initial assert (DEPTH >= 2) else $error("iwr_ingress_arb: DEPTH must be at least 2");

   always_comb begin
      free_slots = CW'(DEPTH) - occupancy;
      hub_fits   = (free_slots != '0);
      // hub link goes first; PCI-style needs a second slot when both ask
      pci_fits   = hub_vld ? (free_slots >= CW'(2)) : (free_slots != '0);
      hub_push   = hub_vld &&  hub_fits;
      pci_push   = pci_vld &&  pci_fits;
      hub_rty    = hub_vld && !hub_fits;
      pci_rty    = pci_vld && !pci_fits;
   end

   // R9: retry only answers a live request
   a_r9_hub_retry_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      hub_rty |-> hub_vld);
   a_r9_pci_retry_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      pci_rty |-> pci_vld);
   // R4: PCI-style never wins a slot the hub link was denied
   a_r4_hub_priority: assert property (@(posedge clk) disable iff (!rst_n)
      (pci_push && hub_vld) |-> hub_push);
endmodule

// File: rtl/iwr_post_fifo.sv
module iwr_post_fifo #(
   parameter int unsigned DEPTH   = iwr_pkg::IWR_DEPTH,
   parameter int unsigned ENT_W   = 1 + iwr_pkg::IWR_ADDR_W + iwr_pkg::IWR_DATA_W,
   localparam int unsigned PW     = $clog2(DEPTH),
   localparam int unsigned CW     = $clog2(DEPTH + 1),
   localparam bit          POW2   = (DEPTH == (1 << PW))
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_a,
   input  logic [ENT_W-1:0] ent_a,
   input  logic             push_b,
   input  logic [ENT_W-1:0] ent_b,
   input  logic             pop,
   output logic             head_vld,
   output logic [ENT_W-1:0] head_ent,
   output logic [CW-1:0]    occupancy
);
   logic [ENT_W-1:0] slots [DEPTH];
   logic [PW-1:0]    wr_ptr, rd_ptr;
   logic [PW-1:0]    wr_p1, wr_p2, rd_p1;
   logic [PW-1:0]    b_idx;
   logic [CW-1:0]    count_q;
   logic [1:0]       n_push;

   initial assert (DEPTH >= 2) else $error("iwr_post_fifo: DEPTH must be at least 2");

   generate
      if (POW2) begin : g_wrap_free
         always_comb begin
            wr_p1 = wr_ptr + PW'(1);
            wr_p2 = wr_ptr + PW'(2);
            rd_p1 = rd_ptr + PW'(1);
         end
      end else begin : g_wrap_cmp
         always_comb begin
            wr_p1 = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
            wr_p2 = (wr_p1  == PW'(DEPTH - 1)) ? '0 : wr_p1  + PW'(1);
            rd_p1 = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
         end
      end
   endgenerate

   always_comb begin
      b_idx  = push_a ? wr_p1 : wr_ptr;
      n_push = {1'b0, push_a} + {1'b0, push_b};
   end

   generate
      for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
         always_ff @(posedge clk) begin
            if (push_a && (wr_ptr == PW'(gi)))
               slots[gi] <= ent_a;
            else if (push_b && (b_idx == PW'(gi)))
               slots[gi] <= ent_b;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         count_q <= '0;
      end else begin
         case (n_push)
            2'd1:    wr_ptr <= wr_p1;
            2'd2:    wr_ptr <= wr_p2;
            default: wr_ptr <= wr_ptr;
         endcase
         if (pop) rd_ptr <= rd_p1;
         count_q <= count_q + CW'(n_push) - CW'(pop);
      end
   end

   always_comb begin
      occupancy = count_q;
      head_vld  = (count_q != '0);
      head_ent  = slots[rd_ptr];
   end

   // R3: nothing is stored once the queue is full
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q == CW'(DEPTH)) |-> !(push_a || push_b));
   a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> head_vld);
endmodule

// File: rtl/iwr_class_steer.sv
module iwr_class_steer #(
   parameter int unsigned ADDR_W   = iwr_pkg::IWR_ADDR_W,
   parameter int unsigned DATA_W   = iwr_pkg::IWR_DATA_W,
   parameter int unsigned WIN_BITS = iwr_pkg::IWR_WIN_BITS,
   parameter logic [WIN_BITS-1:0] WIN_TAG = iwr_pkg::IWR_WIN_TAG,
   localparam int unsigned ENT_W   = 1 + ADDR_W + DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              head_vld,
   input  logic [ENT_W-1:0]  head_ent,
   output logic              pop,
   output logic              mem_vld,
   input  logic              mem_rdy,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_data,
   output logic              irq_vld,
   input  logic              irq_rdy,
   output logic [ADDR_W-1:0] irq_addr,
   output logic [DATA_W-1:0] irq_data
);
   logic              h_elig;
   logic [ADDR_W-1:0] h_addr;
   logic [DATA_W-1:0] h_data;
   logic              in_window;

   initial assert (ADDR_W >= WIN_BITS) else $error("iwr_class_steer: window wider than address");

   always_comb begin
      {h_elig, h_addr, h_data} = head_ent;
      in_window = (h_addr[ADDR_W-1 -: WIN_BITS] == WIN_TAG);
      irq_vld   = head_vld &&  (h_elig && in_window);
      mem_vld   = head_vld && !(h_elig && in_window);
      irq_addr  = h_addr;
      irq_data  = h_data;
      mem_addr  = h_addr;
      mem_data  = h_data;
      pop       = (irq_vld && irq_rdy) || (mem_vld && mem_rdy);
   end

   // R5: one head, one output
   a_r5_one_output: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_vld && mem_vld));
   // R1: interrupt output carries window addresses only
   a_r1_irq_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      irq_vld |-> (irq_addr[ADDR_W-1 -: WIN_BITS] == WIN_TAG));
   // R6: stalled outputs hold
   a_r6_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_vld && !irq_rdy) |=> (irq_vld && $stable(irq_addr) && $stable(irq_data)));
   a_r6_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_vld && !mem_rdy) |=> (mem_vld && $stable(mem_addr) && $stable(mem_data)));
endmodule

// File: rtl/intr_write_router.sv
module intr_write_router #(
   parameter int unsigned ADDR_W   = iwr_pkg::IWR_ADDR_W,
   parameter int unsigned DATA_W   = iwr_pkg::IWR_DATA_W,
   parameter int unsigned DEPTH    = iwr_pkg::IWR_DEPTH,
   parameter int unsigned WIN_BITS = iwr_pkg::IWR_WIN_BITS,
   parameter logic [WIN_BITS-1:0] WIN_TAG = iwr_pkg::IWR_WIN_TAG
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hub_valid,
   input  logic [ADDR_W-1:0] hub_addr,
   input  logic [DATA_W-1:0] hub_data,
   output logic              hub_retry,
   input  logic              pci_valid,
   input  logic              pci_pcisem,
   input  logic [ADDR_W-1:0] pci_addr,
   input  logic [DATA_W-1:0] pci_data,
   output logic              pci_retry,
   output logic              mem_out_valid,
   input  logic              mem_out_ready,
   output logic [ADDR_W-1:0] mem_out_addr,
   output logic [DATA_W-1:0] mem_out_data,
   output logic              irq_out_valid,
   input  logic              irq_out_ready,
   output logic [ADDR_W-1:0] irq_out_addr,
   output logic [DATA_W-1:0] irq_out_data
);
   import iwr_pkg::*;

   localparam int unsigned ENT_W = 1 + ADDR_W + DATA_W;
   localparam int unsigned CW    = $clog2(DEPTH + 1);

   logic             hub_push, pci_push, pop, head_vld;
   logic [ENT_W-1:0] hub_ent, pci_ent, head_ent;
   logic [CW-1:0]    occupancy;

   always_comb begin
      hub_ent = {iwr_irq_eligible(SRC_HUB, 1'b1), hub_addr, hub_data};
      pci_ent = {iwr_irq_eligible(SRC_PCI, pci_pcisem), pci_addr, pci_data};
   end

   iwr_ingress_arb #(.DEPTH(DEPTH)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .hub_vld   (hub_valid),
      .pci_vld   (pci_valid),
      .occupancy (occupancy),
      .hub_push  (hub_push),
      .pci_push  (pci_push),
      .hub_rty   (hub_retry),
      .pci_rty   (pci_retry)
   );

   iwr_post_fifo #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_a    (hub_push),
      .ent_a     (hub_ent),
      .push_b    (pci_push),
      .ent_b     (pci_ent),
      .pop       (pop),
      .head_vld  (head_vld),
      .head_ent  (head_ent),
      .occupancy (occupancy)
   );

   iwr_class_steer #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_BITS(WIN_BITS), .WIN_TAG(WIN_TAG)
   ) u_steer (
      .clk      (clk),
      .rst_n    (rst_n),
      .head_vld (head_vld),
      .head_ent (head_ent),
      .pop      (pop),
      .mem_vld  (mem_out_valid),
      .mem_rdy  (mem_out_ready),
      .mem_addr (mem_out_addr),
      .mem_data (mem_out_data),
      .irq_vld  (irq_out_valid),
      .irq_rdy  (irq_out_ready),
      .irq_addr (irq_out_addr),
      .irq_data (irq_out_data)
   );

   // R2: a PCI-style write without PCI semantics never becomes an interrupt
   a_r2_nosem_is_memory: assert property (@(posedge clk) disable iff (!rst_n)
      (pci_push && !hub_push && !pci_pcisem && !head_vld) |=> !irq_out_valid);
endmodule

// File: tb/intr_write_router_test.sv
module intr_write_router_test;
   localparam int DEPTH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hub_valid = 1'b0, pci_valid = 1'b0, pci_pcisem = 1'b0;
   logic [31:0] hub_addr = '0, hub_data = '0, pci_addr = '0, pci_data = '0;
   logic        mem_out_ready = 1'b0, irq_out_ready = 1'b0;
   logic        hub_retry, pci_retry, mem_out_valid, irq_out_valid;
   logic [31:0] mem_out_addr, mem_out_data, irq_out_addr, irq_out_data;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;
   bit prev_stall = 1'b0;

   // model entry: {from_pci, to_irq, addr, data}
   logic [65:0] model_q[$];

   always #5 clk = ~clk;

   intr_write_router uut (.*);

   function automatic logic exp_irq(logic from_pci, logic sem, logic [31:0] a);
      return (!from_pci || sem) && (a[31:20] == 12'hFEE);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(logic hv, logic [31:0] ha, logic [31:0] hd,
                       logic pv, logic ps, logic [31:0] pa, logic [31:0] pd,
                       logic mr, logic ir);
      int   free;
      logic e_hr, e_pr, e_irq;
      logic [65:0] h;
      string lbl;
      @(negedge clk);
      hub_valid = hv; hub_addr = ha; hub_data = hd;
      pci_valid = pv; pci_pcisem = ps; pci_addr = pa; pci_data = pd;
      mem_out_ready = mr; irq_out_ready = ir;
      #1;
      free = DEPTH - model_q.size();
      e_hr = hv && (free == 0);
      e_pr = pv && (hv ? (free < 2) : (free == 0));
      check(!hv ? "R9" : (free == 0 && (mr || ir)) ? "R7" : "R3",
            32'(hub_retry), 32'(e_hr));
      check(!pv ? "R9" : hv ? "R4" : "R3", 32'(pci_retry), 32'(e_pr));
      if (model_q.size() == 0) begin
         check("R5", 32'({irq_out_valid, mem_out_valid}), 32'd0);
         prev_stall = 1'b0;
      end else begin
         h = model_q[0];
         e_irq = h[64];
         lbl = prev_stall ? "R6" : h[65] ? "R2" : "R1";
         check(lbl, 32'({irq_out_valid, mem_out_valid}), 32'({e_irq, !e_irq}));
         if (e_irq) begin
            check(lbl, irq_out_addr, h[63:32]);
            check(lbl, irq_out_data, h[31:0]);
         end else begin
            check(lbl, mem_out_addr, h[63:32]);
            check(lbl, mem_out_data, h[31:0]);
         end
         prev_stall = e_irq ? !ir : !mr;
         if (!prev_stall) void'(model_q.pop_front());
      end
      if (hv && !e_hr) model_q.push_back({1'b0, exp_irq(1'b0, 1'b1, ha), ha, hd});
      if (pv && !e_pr) model_q.push_back({1'b1, exp_irq(1'b1, ps, pa), pa, pd});
   endtask

   function automatic logic [31:0] rnd_addr();
      return ($urandom_range(0, 9) < 4) ? {12'hFEE, 20'($urandom)} : $urandom;
   endfunction

   initial begin
      #300000;
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      pci_valid = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R8: reset state
      check("R8", 32'({irq_out_valid, mem_out_valid}), 32'd0);
      rst_n = 1'b1;
      pci_valid = 1'b0;
      #1;
      check("R8", 32'({hub_retry, pci_retry}), 32'd0);

      // R1: hub window write, then plain write; consumers stalled (R6)
      step(1, 32'hFEE0_1000, 32'h11, 0, 0, 0, 0, 0, 0);
      step(1, 32'hFED0_0000, 32'h22, 0, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0, 0, 0);
      // R4: both request with 2 free -> both taken; then 0 free
      step(1, 32'h0000_1234, 32'h33, 1, 1, 32'hFEEF_FFFC, 32'h44, 0, 0);
      // R3: full, both retried
      step(1, 32'hFEE0_0000, 32'h55, 1, 1, 32'h1, 32'h66, 0, 0);
      // R7: full with a departure in the same cycle still retries
      step(1, 32'hFEE0_0004, 32'h77, 0, 0, 0, 0, 1, 1);
      // R4: one free slot with both requesting -> PCI-style retried
      step(1, 32'hFEE0_0008, 32'h88, 1, 1, 32'h2, 32'h99, 0, 0);
      // drain
      repeat (6) step(0, 0, 0, 0, 0, 0, 0, 1, 1);
      // R2: PCI-style without PCI semantics in the window -> memory output
      step(0, 0, 0, 1, 0, 32'hFEE0_0ABC, 32'hAA, 1, 1);
      step(0, 0, 0, 1, 1, 32'hFEE0_0ABC, 32'hBB, 1, 1);
      repeat (3) step(0, 0, 0, 0, 0, 0, 0, 1, 1);

      // constrained random
      for (int i = 0; i < 3000; i++) begin
         step($urandom_range(0, 9) < 6, rnd_addr(), $urandom,
              $urandom_range(0, 9) < 6, $urandom_range(0, 3) != 0, rnd_addr(), $urandom,
              $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
      end
      repeat (8) step(0, 0, 0, 0, 0, 0, 0, 1, 1);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule